// File: doc/BRIEF.md
# Impulse-Aware Pipelined Window Rank Sorter

This block takes one 3x3 neighbourhood of pixels per clock, with a valid strobe, and produces the order statistics that an impulse-noise restoration filter needs to replace a corrupted centre pixel. Any pixel at either end of the value range, fully dark or fully bright, is treated as a salt-and-pepper impulse and forced to zero before ranking. The nine values then pass through a fixed compare-and-swap network, with a register after every comparator layer. The network sorts them ascending.

The sorted window yields the minimum, the median and the maximum. It also yields a flag that says whether the median is trustworthy, the number of noise-free pixels, and a median taken only over the noise-free pixels. The last output is the noise-free value nearest to the plain median, which serves as a fallback when the median itself is an impulse. An all-noisy flag marks windows with no usable pixel, so the filter that follows can grow its window. The choice of the final pixel and the line buffering stay outside this block.

Top module: `pix_rank_sorter`

## Requirements
- R1: A pixel equal to 0 or to the all-ones value (255 for 8 bits) is noise and enters the sorter as 0, so no output ever carries 255.
- R2: The nine mapped values are sorted ascending; out_min, out_med and out_max are sorted positions 0, 4 and 8.
- R3: out_med_noisy is 0 exactly when out_min < out_med < out_max holds strictly, and 1 otherwise (including equal values).
- R4: out_clean_cnt is the number of input pixels that are not noise (0 to 9).
- R5: out_clean_med is the median of the noise-free values; when their count is even it is the lower of the two central values.
- R6: out_nearest is the noise-free value with the smallest absolute difference from out_med; on a tie the smaller value wins.
- R7: When no pixel is noise-free, out_all_noisy is 1 and out_clean_med and out_nearest are 0; otherwise out_all_noisy is 0.
- R8: Every window with in_valid high produces out_valid high exactly 10 cycles later (9 comparator layers plus one output register); a window is accepted every cycle and gaps in in_valid appear as gaps in out_valid.
- R9: A synchronous active-high reset clears out_valid in the cycle after it is sampled and discards windows in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window strobe |
| in_pix | input | 72 | Nine 8-bit pixels, pixel k in bits [8k+7:8k] |
| out_valid | output | 1 | Result strobe, 10 cycles after in_valid |
| out_min | output | 8 | Smallest mapped value |
| out_med | output | 8 | Middle mapped value |
| out_max | output | 8 | Largest mapped value |
| out_med_noisy | output | 1 | Median fails the strict bracket test |
| out_clean_cnt | output | 4 | Number of noise-free pixels |
| out_clean_med | output | 8 | Lower median of noise-free values |
| out_nearest | output | 8 | Noise-free value nearest the median |
| out_all_noisy | output | 1 | No noise-free pixel in the window |

## Verification
Every cycle, the assertions check the valid timing against a delayed copy of in_valid, the ordering min <= med <= max, the absence of 255 at the outputs, and the consistency of the all-noisy flag with the count and the zeroed fallback outputs. They also check that a trusted median is non-zero and that reset empties the pipe. Only the bench's reference model can show that the values are the correct order statistics. This covers the exact median and extremes, the lower-central choice for an even clean count, and which clean value is nearest. The bench runs these over directed windows (equal values, edge values 1 and 254, all noise, an even clean count) and over a long stream of random windows with gaps and a mid-stream reset.

// File: rtl/pix_rank_pkg.sv
package pix_rank_pkg;

    localparam int PIX_W_DEF = 8;
    localparam int NWIN_DEF  = 9;

    // Impulse test: either end of the value range.
    function automatic logic is_impulse(input logic [PIX_W_DEF-1:0] v);
        return (v == '0) || (v == '1);
    endfunction

    // Magnitude of the difference of two pixel values.
    function automatic logic [PIX_W_DEF-1:0] abs_diff(input logic [PIX_W_DEF-1:0] a,
                                                      input logic [PIX_W_DEF-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/pix_noise_map.sv
module pix_noise_map
    import pix_rank_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int NWIN  = NWIN_DEF
) (
    input  logic [NWIN-1:0][PIX_W-1:0] raw,
    output logic [NWIN-1:0][PIX_W-1:0] mapped
);

    genvar k;
    generate
        for (k = 0; k < NWIN; k++) begin : g_pix
            logic hit;
            assign hit       = (raw[k] == '0) || (raw[k] == '1);
            assign mapped[k] = hit ? '0 : raw[k];
        end
    endgenerate

endmodule

// File: rtl/pix_cas_layer.sv
module pix_cas_layer
    import pix_rank_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int NWIN  = NWIN_DEF,
    parameter int PHASE = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       vld_i,
    input  logic [NWIN-1:0][PIX_W-1:0] d_i,
    output logic                       vld_o,
    output logic [NWIN-1:0][PIX_W-1:0] d_o
);

    logic [NWIN-1:0][PIX_W-1:0] nxt;

    genvar k;
    generate
        for (k = 0; k < NWIN; k++) begin : g_lane
            if ((k % 2 == PHASE) && (k + 1 < NWIN)) begin : g_lo
                assign nxt[k] = (d_i[k] > d_i[k+1]) ? d_i[k+1] : d_i[k];
            end else if ((k >= 1) && ((k - 1) % 2 == PHASE)) begin : g_hi
                assign nxt[k] = (d_i[k-1] > d_i[k]) ? d_i[k-1] : d_i[k];
            end else begin : g_pass
                assign nxt[k] = d_i[k];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            d_o   <= '0;
        end else begin
            vld_o <= vld_i;
            d_o   <= nxt;
        end
    end

endmodule

// File: rtl/pix_rank_stats.sv
module pix_rank_stats
    import pix_rank_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int NWIN  = NWIN_DEF,
    localparam int CNT_W = $clog2(NWIN + 1),
    localparam int MID   = NWIN / 2
) (
    input  logic [NWIN-1:0][PIX_W-1:0] srt,
    output logic [PIX_W-1:0]           mn,
    output logic [PIX_W-1:0]           md,
    output logic [PIX_W-1:0]           mx,
    output logic                       md_noisy,
    output logic [CNT_W-1:0]           cnt,
    output logic [PIX_W-1:0]           cmed,
    output logic [PIX_W-1:0]           near,
    output logic                       none
);

    int          n_clean;
    int          cidx;
    int          best_d;
    int          d;

    assign mn       = srt[0];
    assign md       = srt[MID];
    assign mx       = srt[NWIN-1];
    assign md_noisy = !((srt[0] < srt[MID]) && (srt[MID] < srt[NWIN-1]));

    always_comb begin
        n_clean = 0;
        for (int i = 0; i < NWIN; i++) begin
            if (srt[i] != '0) n_clean = n_clean + 1;
        end
        cnt  = CNT_W'(n_clean);
        none = (n_clean == 0);

        // Clean entries sit at the top of the sorted vector.
        cidx = (NWIN - n_clean) + (n_clean - 1) / 2;
        cmed = '0;
        for (int i = 0; i < NWIN; i++) begin
            if ((n_clean != 0) && (i == cidx)) cmed = srt[i];
        end

        // Ascending scan with strict improvement keeps the smaller value on a tie.
        near   = '0;
        best_d = 1 << PIX_W;
        d      = 0;
        for (int i = 0; i < NWIN; i++) begin
            d = int'(srt[i]) - int'(srt[MID]);
            if (d < 0) d = -d;
            if ((srt[i] != '0) && (d < best_d)) begin
                best_d = d;
                near   = srt[i];
            end
        end
    end

endmodule

// File: rtl/pix_rank_sorter.sv
module pix_rank_sorter
    import pix_rank_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int NWIN  = NWIN_DEF,
    localparam int CNT_W  = $clog2(NWIN + 1),
    localparam int LAYERS = NWIN
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [NWIN-1:0][PIX_W-1:0] in_pix,
    output logic                       out_valid,
    output logic [PIX_W-1:0]           out_min,
    output logic [PIX_W-1:0]           out_med,
    output logic [PIX_W-1:0]           out_max,
    output logic                       out_med_noisy,
    output logic [CNT_W-1:0]           out_clean_cnt,
    output logic [PIX_W-1:0]           out_clean_med,
    output logic [PIX_W-1:0]           out_nearest,
    output logic                       out_all_noisy
);

    logic [LAYERS:0]                       stg_v;
    logic [LAYERS:0][NWIN-1:0][PIX_W-1:0]  stg_d;

    assign stg_v[0] = in_valid;

    pix_noise_map #(.PIX_W(PIX_W), .NWIN(NWIN)) i_map (
        .raw    (in_pix),
        .mapped (stg_d[0])
    );

    genvar L;
    generate
        for (L = 0; L < LAYERS; L++) begin : g_layer
            pix_cas_layer #(.PIX_W(PIX_W), .NWIN(NWIN), .PHASE(L % 2)) i_layer (
                .clk   (clk),
                .rst   (rst),
                .vld_i (stg_v[L]),
                .d_i   (stg_d[L]),
                .vld_o (stg_v[L+1]),
                .d_o   (stg_d[L+1])
            );
        end
    endgenerate

    logic [PIX_W-1:0] s_mn, s_md, s_mx, s_cmed, s_near;
    logic             s_noisy, s_none;
    logic [CNT_W-1:0] s_cnt;

    pix_rank_stats #(.PIX_W(PIX_W), .NWIN(NWIN)) i_stats (
        .srt      (stg_d[LAYERS]),
        .mn       (s_mn),
        .md       (s_md),
        .mx       (s_mx),
        .md_noisy (s_noisy),
        .cnt      (s_cnt),
        .cmed     (s_cmed),
        .near     (s_near),
        .none     (s_none)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            out_min       <= '0;
            out_med       <= '0;
            out_max       <= '0;
            out_med_noisy <= 1'b0;
            out_clean_cnt <= '0;
            out_clean_med <= '0;
            out_nearest   <= '0;
            out_all_noisy <= 1'b0;
        end else begin
            out_valid     <= stg_v[LAYERS];
            out_min       <= s_mn;
            out_med       <= s_md;
            out_max       <= s_mx;
            out_med_noisy <= s_noisy;
            out_clean_cnt <= s_cnt;
            out_clean_med <= s_cmed;
            out_nearest   <= s_near;
            out_all_noisy <= s_none;
        end
    end

endmodule

// File: rtl/pix_rank_checker.sv
module pix_rank_checker
    import pix_rank_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int NWIN  = NWIN_DEF,
    localparam int CNT_W = $clog2(NWIN + 1),
    localparam int LAT   = NWIN + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_min,
    input logic [PIX_W-1:0] out_med,
    input logic [PIX_W-1:0] out_max,
    input logic             out_med_noisy,
    input logic [CNT_W-1:0] out_clean_cnt,
    input logic [PIX_W-1:0] out_clean_med,
    input logic [PIX_W-1:0] out_nearest,
    input logic             out_all_noisy
);

    logic [LAT-1:0] vpipe;

    always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[LAT-2:0], in_valid};
    end

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid == vpipe[LAT-1]);

    assert_sorted_order_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_min <= out_med) && (out_med <= out_max));

    assert_no_bright_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_max != '1));

    assert_trusted_median_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_med_noisy) |-> (out_med != '0) && (out_min < out_med));

    assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_clean_cnt <= CNT_W'(NWIN)));

    assert_clean_med_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_all_noisy) |-> (out_clean_med != '0) && (out_clean_med <= out_max));

    assert_nearest_clean_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_all_noisy) |-> (out_nearest != '0));

    assert_all_noisy_flag_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_all_noisy == (out_clean_cnt == '0)));

    assert_all_noisy_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_all_noisy) |-> (out_nearest == '0) && (out_clean_med == '0));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind pix_rank_sorter pix_rank_checker #(.PIX_W(PIX_W), .NWIN(NWIN)) i_chk (.*);

// File: tb/test_pix_rank_sorter.sv
module test_pix_rank_sorter;

    localparam int PW  = 8;
    localparam int NW  = 9;
    localparam int LAT = NW + 1;
    localparam int MAXV = (1 << PW) - 1;

    typedef struct {
        bit vld;
        bit from_rst;
        int mn, md, mx, noisy, cnt, cmed, near, alln;
    } exp_t;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic [NW-1:0][PW-1:0]  in_pix = '0;
    logic                   out_valid;
    logic [PW-1:0]          out_min, out_med, out_max, out_clean_med, out_nearest;
    logic                   out_med_noisy, out_all_noisy;
    logic [3:0]             out_clean_cnt;

    int   errors = 0;
    int   checks = 0;
    int   cycles = 0;
    bit   done   = 0;
    int   lcg    = 32'h1234_5678;
    exp_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    pix_rank_sorter i_pix_rank_sorter (
        .clk, .rst, .in_valid, .in_pix, .out_valid, .out_min, .out_med, .out_max,
        .out_med_noisy, .out_clean_cnt, .out_clean_med, .out_nearest, .out_all_noisy
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: act=%0d cycles exp<=200000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic exp_t model(input int w[NW]);
        exp_t e;
        int   v[NW];
        int   cl[$];
        int   t, bd, dd;
        for (int i = 0; i < NW; i++) v[i] = (w[i] == 0 || w[i] == MAXV) ? 0 : w[i];
        for (int a = 0; a < NW; a++)
            for (int b = 0; b < NW - 1 - a; b++)
                if (v[b] > v[b+1]) begin t = v[b]; v[b] = v[b+1]; v[b+1] = t; end
        e.vld = 1; e.from_rst = 0;
        e.mn = v[0]; e.md = v[NW/2]; e.mx = v[NW-1];
        e.noisy = (e.mn < e.md && e.md < e.mx) ? 0 : 1;
        for (int i = 0; i < NW; i++) if (v[i] != 0) cl.push_back(v[i]);
        e.cnt  = cl.size();
        e.alln = (e.cnt == 0);
        e.cmed = (e.cnt == 0) ? 0 : cl[(e.cnt - 1) / 2];
        e.near = 0; bd = 1 << 30;
        foreach (cl[i]) begin
            dd = cl[i] - e.md; if (dd < 0) dd = -dd;
            if (dd < bd) begin bd = dd; e.near = cl[i]; end
        end
        return e;
    endfunction

    task automatic compare(input exp_t e);
        if (!e.vld) begin
            chk(e.from_rst ? "R9 out_valid after reset" : "R8 out_valid gap", out_valid, 0);
        end else begin
            chk("R8 out_valid", out_valid, 1);
            chk("R2 min", out_min, e.mn);
            chk("R2 median", out_med, e.md);
            chk("R1 R2 max", out_max, e.mx);
            chk("R3 median noisy", out_med_noisy, e.noisy);
            chk("R4 clean count", out_clean_cnt, e.cnt);
            chk("R5 clean median", out_clean_med, e.cmed);
            chk("R6 nearest", out_nearest, e.near);
            chk("R7 all noisy", out_all_noisy, e.alln);
        end
    endtask

    task automatic step(input bit r, input bit v, input int w[NW]);
        exp_t e;
        @(negedge clk);
        if (q.size() == LAT) compare(q.pop_front());
        rst      = r;
        in_valid = v;
        for (int i = 0; i < NW; i++) in_pix[i] = PW'(w[i]);
        if (r) begin
            q.delete();
            for (int i = 0; i < LAT; i++) begin
                e = '{vld: 0, from_rst: 1, default: 0};
                q.push_back(e);
            end
        end else if (v) begin
            q.push_back(model(w));
        end else begin
            e = '{vld: 0, from_rst: 0, default: 0};
            q.push_back(e);
        end
    endtask

    function automatic int rnd();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 8) & 32'h7fff;
    endfunction

    initial begin
        int z[NW];
        int w[NW];
        foreach (z[i]) z[i] = 0;
        for (int i = 0; i < 3; i++) step(1, 0, z);
        // R9 reset state visible at the output
        @(negedge clk); chk("R9 reset state out_valid", out_valid, 0);
        step(0, 0, z);
        // distinct clean values (R2, R3 trusted median)
        w = '{50, 10, 90, 30, 70, 20, 80, 40, 60}; step(0, 1, w);
        // one dark and one bright impulse (R1)
        w = '{0, 255, 5, 6, 7, 8, 9, 10, 11};      step(0, 1, w);
        // all bright (R7)
        w = '{255, 255, 255, 255, 255, 255, 255, 255, 255}; step(0, 1, w);
        // mixed all-noise (R7)
        w = '{0, 255, 0, 255, 0, 255, 0, 255, 0};  step(0, 1, w);
        // six impulses, odd clean count, noisy median (R5, R6)
        w = '{0, 0, 0, 255, 255, 255, 100, 40, 200}; step(0, 1, w);
        // five impulses, even clean count, lower central (R5)
        w = '{30, 60, 0, 255, 0, 255, 0, 90, 120}; step(0, 1, w);
        // equal values: strict bracket fails (R3)
        w = '{128, 128, 128, 128, 128, 128, 128, 128, 128}; step(0, 1, w);
        // range edges 1 and 254 are not noise (R1, R4)
        w = '{1, 254, 1, 254, 1, 254, 1, 254, 1};  step(0, 1, w);
        // single clean pixel (R5, R6)
        w = '{0, 255, 0, 255, 77, 255, 0, 255, 0}; step(0, 1, w);
        // back-to-back and gapped random stream (R8)
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NW; i++) begin
                int r;
                r = rnd() % 10;
                w[i] = (r < 2) ? 0 : (r < 4) ? 255 : 1 + rnd() % 254;
            end
            step(0, (rnd() % 5) != 0, w);
        end
        // reset with windows in flight (R9)
        step(1, 1, w);
        step(0, 1, w);
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < NW; i++) w[i] = rnd() % 256;
            step(0, 1, w);
        end
        for (int n = 0; n < LAT + 2; n++) step(0, 0, z);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule